// File: doc/BRIEF.md
# Watermarked Sample Buffer Request Controller

This block keeps two circular sample queues inside one shared local memory. The input queue is filled by a host-side write port and drained by a processing-engine port. The output queue is filled by the engine and drained by a host-side read port. Each queue has its own base address, size and watermark. The two queues may share the same region, so that each result the engine writes takes the place of the oldest input sample.

The input queue raises a full flag when its free space drops below a power-of-two threshold. The output queue raises an empty flag when its unread sample count drops below a power-of-two threshold. The flags, together with four enable bits, drive a separate interrupt line and a separate DMA request line for each direction. Each direction can therefore be polled, serviced by interrupt or serviced by DMA, independently of the other. If both the interrupt enable and the DMA enable are set for one direction, only the DMA line is raised.

Top module: `sbuf_req_ctrl`

## Requirements
- R1: After a synchronous reset, `in_full`, all four request lines, `err_wr` and `err_rd` are low, and `out_empty` is high. The reset configuration for both queues is base 0, size equal to the memory depth, and watermark 0.
- R2: A configuration write to address 0 (input queue) or address 1 (output queue) loads that queue's fields and clears its pointers and occupancy. The fields are: base in bits [7:0], size from bit 8 (clamped to the memory depth), and watermark exponent from bit 16.
- R3: An accepted host write stores `wr_data` at the input base plus the write pointer. The pointer wraps to 0 at the programmed size. The engine reads input samples in the order they were written.
- R4: `in_full` is high exactly when the input queue's free space (size minus occupancy) is less than 2 to the power of the input watermark.
- R5: `out_empty` is high exactly when the output queue's occupancy is less than 2 to the power of the output watermark.
- R6: `rd_data` shows the oldest unread output sample, taken from the output base plus the read pointer, which wraps at the programmed size. An accepted `host_rd` advances the read pointer.
- R7: A host write while `in_full` is high is ignored: no storage, no pointer movement. It sets the sticky `err_wr`, which only reset clears.
- R8: A host read while `out_empty` is high is ignored, with no pointer movement. It sets the sticky `err_rd`, which only reset clears.
- R9: With every enable clear (configuration address 2, bits [3:0] = 0), no request line is ever raised.
- R10: With enable bit 0 (write interrupt) set, `irq_wr` follows the inverse of `in_full`. With enable bit 1 (read interrupt) set, `irq_rd` follows the inverse of `out_empty`. In each case this holds only while that direction's DMA enable is clear.
- R11: With enable bit 2 set, `dma_wr` follows the inverse of `in_full`. With enable bit 3 set, `dma_rd` follows the inverse of `out_empty`. A set DMA enable suppresses the interrupt line of the same direction.
- R12: When both queues are given the same base and size, the output sample pushed in the same cycle as an input pop is written over the input sample just consumed, and is returned on `rd_data`.
- R13: `eng_in_data` shows the oldest input sample. `eng_pop` on an empty input queue and `eng_push` on a full output queue (occupancy equal to size) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select (0 input queue, 1 output queue, 2 enables) |
| cfg_wdata | input | 32 | Configuration write data |
| host_wr | input | 1 | Host sample write strobe |
| wr_data | input | DW | Host sample to store |
| host_rd | input | 1 | Host sample read strobe |
| rd_data | output | DW | Oldest unread output sample |
| eng_pop | input | 1 | Engine consumes one input sample |
| eng_in_data | output | DW | Oldest input sample |
| eng_push | input | 1 | Engine produces one output sample |
| eng_out_data | input | DW | Output sample from engine |
| in_full | output | 1 | Input queue free space below watermark |
| out_empty | output | 1 | Output queue occupancy below watermark |
| irq_wr | output | 1 | Write-direction interrupt request |
| irq_rd | output | 1 | Read-direction interrupt request |
| dma_wr | output | 1 | Write-direction DMA request |
| dma_rd | output | 1 | Read-direction DMA request |
| err_wr | output | 1 | Sticky: write attempted while full |
| err_rd | output | 1 | Sticky: read attempted while empty |

## Verification
The checker relies on `rst` being held for at least one clock edge before any traffic, so that the configuration and flags start from known values. It also relies on inputs changing only between edges. The bench holds reset for three cycles and drives every strobe from the falling clock edge. The bench also gives the checker a non-trivial case to evaluate: it deliberately writes into a full queue and reads from an empty one, so that the error-setting and stickiness properties fire on real traffic.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
   typedef enum logic [1:0] {
      SEL_INQ  = 2'd0,
      SEL_OUTQ = 2'd1,
      SEL_EN   = 2'd2
   } cfg_sel_e;

   localparam int F_BASE_LSB = 0;
   localparam int F_SIZE_LSB = 8;
   localparam int F_WM_LSB   = 16;

   localparam int EN_WR_IRQ = 0;
   localparam int EN_RD_IRQ = 1;
   localparam int EN_WR_DMA = 2;
   localparam int EN_RD_DMA = 3;

   localparam int DIR_WR = 0;
   localparam int DIR_RD = 1;
endpackage

// File: rtl/sbuf_ring.sv
module sbuf_ring #(
   parameter int AW  = 6,
   parameter int WMW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic [AW-1:0] base,
   input  logic [AW:0]   size,
   input  logic [WMW-1:0] wm,
   input  logic          push,
   input  logic          pop,
   output logic [AW-1:0] push_addr,
   output logic [AW-1:0] pop_addr,
   output logic          room_low,
   output logic          fill_low,
   output logic          has_room,
   output logic          has_data
);
   localparam int CW = AW + 1;
   localparam logic [WMW-1:0] WM_MAX = WMW'(CW);

   logic [CW-1:0] wptr, rptr, count, free_sp;
   logic [CW-1:0] winc, rinc, wsum, rsum;
   logic [CW:0]   thr;
   logic          push_ok, pop_ok;

   assign has_room = (count < size);
   assign has_data = (count != '0);
   assign push_ok  = push & has_room;
   assign pop_ok   = pop & has_data;

   assign winc = wptr + CW'(1);
   assign rinc = rptr + CW'(1);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push_ok) wptr <= (winc >= size) ? '0 : winc;
         if (pop_ok)  rptr <= (rinc >= size) ? '0 : rinc;
         if (push_ok && !pop_ok)      count <= count + CW'(1);
         else if (pop_ok && !push_ok) count <= count - CW'(1);
      end
   end

   assign wsum      = {1'b0, base} + wptr;
   assign rsum      = {1'b0, base} + rptr;
   assign push_addr = wsum[AW-1:0];
   assign pop_addr  = rsum[AW-1:0];

   assign free_sp  = size - count;
   assign thr      = (CW+1)'(1) << wm;
   assign room_low = (wm > WM_MAX) || ({1'b0, free_sp} < thr);
   assign fill_low = (wm > WM_MAX) || ({1'b0, count} < thr);
endmodule

// File: rtl/sbuf_req_sel.sv
module sbuf_req_sel #(
   parameter bit DMA_WINS = 1'b1
) (
   input  logic avail,
   input  logic irq_en,
   input  logic dma_en,
   output logic irq_req,
   output logic dma_req
);
   assign dma_req = avail & dma_en;

   generate
      if (DMA_WINS) begin : g_dma_first
         assign irq_req = avail & irq_en & ~dma_en;
      end else begin : g_both
         assign irq_req = avail & irq_en;
      end
   endgenerate
endmodule

// File: rtl/sbuf_req_ctrl.sv
module sbuf_req_ctrl
   import sbuf_pkg::*;
#(
   parameter int DW       = 16,
   parameter int AW       = 6,
   parameter bit DMA_WINS = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_addr,
   input  logic [31:0]   cfg_wdata,
   input  logic          host_wr,
   input  logic [DW-1:0] wr_data,
   input  logic          host_rd,
   output logic [DW-1:0] rd_data,
   input  logic          eng_pop,
   output logic [DW-1:0] eng_in_data,
   input  logic          eng_push,
   input  logic [DW-1:0] eng_out_data,
   output logic          in_full,
   output logic          out_empty,
   output logic          irq_wr,
   output logic          irq_rd,
   output logic          dma_wr,
   output logic          dma_rd,
   output logic          err_wr,
   output logic          err_rd
);
   localparam int DEPTH = 1 << AW;
   localparam int CW    = AW + 1;
   localparam int WMW   = $clog2(CW + 1);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   generate
      if (AW < 2 || AW > 7) begin : g_bad_aw
         $error("sbuf_req_ctrl: AW must lie in 2..7 so fields fit the config word");
      end
      if (DW < 1) begin : g_bad_dw
         $error("sbuf_req_ctrl: DW must be positive");
      end
      if (WMW > 4) begin : g_bad_wm
         $error("sbuf_req_ctrl: watermark field wider than 4 bits");
      end
   endgenerate

   // configuration state
   logic [AW-1:0]  iq_base, oq_base;
   logic [CW-1:0]  iq_size, oq_size;
   logic [WMW-1:0] iq_wm, oq_wm;
   logic [3:0]     en_r;
   logic [CW-1:0]  f_size;
   logic           clr_iq, clr_oq;

   assign f_size = (cfg_wdata[F_SIZE_LSB +: CW] > DEPTH_C) ? DEPTH_C
                                                           : cfg_wdata[F_SIZE_LSB +: CW];
   assign clr_iq = cfg_we && (cfg_addr == SEL_INQ);
   assign clr_oq = cfg_we && (cfg_addr == SEL_OUTQ);

   always_ff @(posedge clk) begin
      if (rst) begin
         iq_base <= '0;
         oq_base <= '0;
         iq_size <= DEPTH_C;
         oq_size <= DEPTH_C;
         iq_wm   <= '0;
         oq_wm   <= '0;
         en_r    <= '0;
      end else if (cfg_we) begin
         unique case (cfg_addr)
            SEL_INQ: begin
               iq_base <= cfg_wdata[F_BASE_LSB +: AW];
               iq_size <= f_size;
               iq_wm   <= cfg_wdata[F_WM_LSB +: WMW];
            end
            SEL_OUTQ: begin
               oq_base <= cfg_wdata[F_BASE_LSB +: AW];
               oq_size <= f_size;
               oq_wm   <= cfg_wdata[F_WM_LSB +: WMW];
            end
            SEL_EN:  en_r <= cfg_wdata[3:0];
            default: ;
         endcase
      end
   end

   // queues
   logic [AW-1:0] iq_waddr, iq_raddr, oq_waddr, oq_raddr;
   logic iq_room_low, iq_fill_low, iq_has_room, iq_has_data;
   logic oq_room_low, oq_fill_low, oq_has_room, oq_has_data;
   logic wr_ok, rd_ok, epush_ok;

   assign wr_ok    = host_wr & ~in_full & iq_has_room;
   assign rd_ok    = host_rd & ~out_empty & oq_has_data;
   assign epush_ok = eng_push & oq_has_room;

   sbuf_ring #(.AW(AW), .WMW(WMW)) u_inq (
      .clk(clk), .rst(rst), .clr(clr_iq),
      .base(iq_base), .size(iq_size), .wm(iq_wm),
      .push(wr_ok), .pop(eng_pop),
      .push_addr(iq_waddr), .pop_addr(iq_raddr),
      .room_low(iq_room_low), .fill_low(iq_fill_low),
      .has_room(iq_has_room), .has_data(iq_has_data)
   );

   sbuf_ring #(.AW(AW), .WMW(WMW)) u_outq (
      .clk(clk), .rst(rst), .clr(clr_oq),
      .base(oq_base), .size(oq_size), .wm(oq_wm),
      .push(eng_push), .pop(rd_ok),
      .push_addr(oq_waddr), .pop_addr(oq_raddr),
      .room_low(oq_room_low), .fill_low(oq_fill_low),
      .has_room(oq_has_room), .has_data(oq_has_data)
   );

   assign in_full   = iq_room_low;
   assign out_empty = oq_fill_low;

   // shared sample store; engine write lands after host write on a clash
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_ok)    mem[iq_waddr] <= wr_data;
      if (epush_ok) mem[oq_waddr] <= eng_out_data;
   end

   assign eng_in_data = mem[iq_raddr];
   assign rd_data     = mem[oq_raddr];

   // sticky misuse flags
   always_ff @(posedge clk) begin
      if (rst) begin
         err_wr <= 1'b0;
         err_rd <= 1'b0;
      end else begin
         if (host_wr && in_full)   err_wr <= 1'b1;
         if (host_rd && out_empty) err_rd <= 1'b1;
      end
   end

   // per-direction request selection
   logic [1:0] avail, ien, den, irq_v, dma_v;
   assign avail[DIR_WR] = ~in_full;
   assign avail[DIR_RD] = ~out_empty;
   assign ien[DIR_WR]   = en_r[EN_WR_IRQ];
   assign ien[DIR_RD]   = en_r[EN_RD_IRQ];
   assign den[DIR_WR]   = en_r[EN_WR_DMA];
   assign den[DIR_RD]   = en_r[EN_RD_DMA];

   generate
      for (genvar d = 0; d < 2; d++) begin : g_dir
         sbuf_req_sel #(.DMA_WINS(DMA_WINS)) u_sel (
            .avail(avail[d]), .irq_en(ien[d]), .dma_en(den[d]),
            .irq_req(irq_v[d]), .dma_req(dma_v[d])
         );
      end
   endgenerate

   assign irq_wr = irq_v[DIR_WR];
   assign irq_rd = irq_v[DIR_RD];
   assign dma_wr = dma_v[DIR_WR];
   assign dma_rd = dma_v[DIR_RD];
endmodule

// File: rtl/sbuf_req_ctrl_chk.sv
module sbuf_req_ctrl_chk (
   input logic clk,
   input logic rst,
   input logic host_wr,
   input logic host_rd,
   input logic in_full,
   input logic out_empty,
   input logic irq_wr,
   input logic irq_rd,
   input logic dma_wr,
   input logic dma_rd,
   input logic err_wr,
   input logic err_rd
);
   AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!in_full && out_empty && !irq_wr && !irq_rd && !dma_wr && !dma_rd && !err_wr && !err_rd)); // R1
   AST_IRQ_WR_ROOM: assert property (@(posedge clk) disable iff (rst) irq_wr |-> !in_full); // R10
   AST_IRQ_RD_DATA: assert property (@(posedge clk) disable iff (rst) irq_rd |-> !out_empty); // R10
   AST_DMA_WR_ROOM: assert property (@(posedge clk) disable iff (rst) dma_wr |-> !in_full); // R11
   AST_DMA_RD_DATA: assert property (@(posedge clk) disable iff (rst) dma_rd |-> !out_empty); // R11
   AST_WR_ONE_PATH: assert property (@(posedge clk) disable iff (rst) !(irq_wr && dma_wr)); // R11
   AST_RD_ONE_PATH: assert property (@(posedge clk) disable iff (rst) !(irq_rd && dma_rd)); // R11
   AST_WR_FULL_ERR: assert property (@(posedge clk) disable iff (rst) (host_wr && in_full) |=> err_wr); // R7
   AST_RD_EMPTY_ERR: assert property (@(posedge clk) disable iff (rst) (host_rd && out_empty) |=> err_rd); // R8
   AST_WR_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err_wr |=> err_wr); // R7
   AST_RD_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err_rd |=> err_rd); // R8
endmodule

bind sbuf_req_ctrl sbuf_req_ctrl_chk u_chk (
   .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
   .in_full(in_full), .out_empty(out_empty),
   .irq_wr(irq_wr), .irq_rd(irq_rd), .dma_wr(dma_wr), .dma_rd(dma_rd),
   .err_wr(err_wr), .err_rd(err_rd)
);

// File: tb/sim_sbuf_req_ctrl.sv
`timescale 1ns/1ps
module sim_sbuf_req_ctrl;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          host_wr = 1'b0, host_rd = 1'b0;
   logic [DW-1:0] wr_data = '0, eng_out_data = '0;
   logic          eng_pop = 1'b0, eng_push = 1'b0;
   logic [DW-1:0] rd_data, eng_in_data;
   logic          in_full, out_empty, irq_wr, irq_rd, dma_wr, dma_rd, err_wr, err_rd;

   int nchk = 0, nfail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sbuf_req_ctrl #(.DW(DW), .AW(6)) u0 (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .host_wr(host_wr), .wr_data(wr_data), .host_rd(host_rd), .rd_data(rd_data),
      .eng_pop(eng_pop), .eng_in_data(eng_in_data), .eng_push(eng_push),
      .eng_out_data(eng_out_data), .in_full(in_full), .out_empty(out_empty),
      .irq_wr(irq_wr), .irq_rd(irq_rd), .dma_wr(dma_wr), .dma_rd(dma_rd),
      .err_wr(err_wr), .err_rd(err_rd)
   );

   // {enables[3:0], expected {dma_rd, dma_wr, irq_rd, irq_wr}} with both directions available
   localparam logic [7:0] VEC [16] = '{
      8'b0000_0000, 8'b0001_0001, 8'b0010_0010, 8'b0011_0011,
      8'b0100_0100, 8'b0101_0100, 8'b0110_0110, 8'b0111_0110,
      8'b1000_1000, 8'b1001_1001, 8'b1010_1000, 8'b1011_1001,
      8'b1100_1100, 8'b1101_1100, 8'b1110_1100, 8'b1111_1100
   };

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic logic [31:0] qword(input int b, input int s, input int w);
      return (32'(w) << 16) | (32'(s) << 8) | 32'(b);
   endfunction

   task automatic cfg(input logic [1:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; tick(); cfg_we = 1'b0;
   endtask

   task automatic hwrite(input logic [DW-1:0] d);
      host_wr = 1'b1; wr_data = d; tick(); host_wr = 1'b0;
   endtask

   task automatic hread();
      host_rd = 1'b1; tick(); host_rd = 1'b0;
   endtask

   task automatic epop();
      eng_pop = 1'b1; tick(); eng_pop = 1'b0;
   endtask

   task automatic epush(input logic [DW-1:0] d);
      eng_push = 1'b1; eng_out_data = d; tick(); eng_push = 1'b0;
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         report();
      end
   end

   initial begin
      repeat (3) tick();
      rst = 1'b0;
      // R1 reset state
      chk("R1 in_full", in_full, 0);
      chk("R1 out_empty", out_empty, 1);
      chk("R1 requests", {dma_rd, dma_wr, irq_rd, irq_wr}, 0);
      chk("R1 errors", {err_wr, err_rd}, 0);

      // input queue base 8, size 6, watermark 1 (full once free < 2)
      cfg(2'd0, qword(8, 6, 1));
      for (int i = 0; i < 4; i++) hwrite(DW'(16'h100 + i));
      chk("R4 four of six not full", in_full, 0);
      hwrite(16'h104);
      chk("R4 five of six full", in_full, 1);
      chk("R9 polling no wr request", {dma_wr, irq_wr}, 0);
      hwrite(16'hDEAD);
      chk("R7 err_wr set", err_wr, 1);
      for (int i = 0; i < 5; i++) begin
         chk("R13 engine order", eng_in_data, 16'h100 + i);
         epop();
      end
      chk("R4 drained not full", in_full, 0);
      chk("R7 err_wr sticky", err_wr, 1);
      // wrap: pointers now at 5
      for (int i = 0; i < 5; i++) hwrite(DW'(16'h200 + i));
      for (int i = 0; i < 5; i++) begin
         chk("R3 wrap order", eng_in_data, 16'h200 + i);
         epop();
      end

      // output queue base 32, size 4, watermark 1 (empty while count < 2)
      cfg(2'd1, qword(32, 4, 1));
      epush(16'h300);
      chk("R5 one sample still empty", out_empty, 1);
      epush(16'h301);
      chk("R5 two samples not empty", out_empty, 0);
      chk("R6 oldest shown", rd_data, 16'h300);
      hread();
      chk("R5 back to one empty", out_empty, 1);
      hread();
      chk("R8 err_rd set", err_rd, 1);
      epush(16'h302);
      chk("R8 ignored read kept pointer", rd_data, 16'h301);
      hread();
      chk("R6 next sample", rd_data, 16'h302);
      epush(16'h303);
      chk("R8 err_rd sticky", err_rd, 1);

      // R9 R10 R11 enable table: input has room, output holds 2 samples
      for (int v = 0; v < 16; v++) begin
         cfg(2'd2, {28'd0, VEC[v][7:4]});
         chk($sformatf("R9 R10 R11 enables=%0d", v),
             {dma_rd, dma_wr, irq_rd, irq_wr}, VEC[v][3:0]);
      end

      // R12 shared region: both queues base 4, size 5, watermark 0
      cfg(2'd0, qword(4, 5, 0));
      cfg(2'd1, qword(4, 5, 0));
      chk("R11 empty blocks read requests", {dma_rd, irq_rd}, 0);
      for (int i = 0; i < 5; i++) hwrite(DW'(16'h400 + i));
      chk("R4 exactly full", in_full, 1);
      chk("R11 full blocks write requests", {dma_wr, irq_wr}, 0);
      chk("R13 oldest input", eng_in_data, 16'h400);
      eng_pop = 1'b1; eng_push = 1'b1; eng_out_data = 16'h4A0;
      tick();
      eng_pop = 1'b0; eng_push = 1'b0;
      chk("R12 result replaces oldest", rd_data, 16'h4A0);
      chk("R12 next input intact", eng_in_data, 16'h401);
      chk("R11 write dma after pop", {dma_wr, irq_wr}, 2'b10);
      chk("R11 read dma after push", {dma_rd, irq_rd}, 2'b10);

      // R2 field positions and pointer clear
      cfg(2'd0, qword(4, 5, 3));
      chk("R2 watermark field makes full", in_full, 1);
      cfg(2'd0, qword(4, 5, 0));
      chk("R2 reconfig clears full", in_full, 0);
      hwrite(16'h500);
      chk("R2 pointer reset to base", eng_in_data, 16'h500);

      // R1 reset restores state
      rst = 1'b1; tick(); rst = 1'b0;
      chk("R1 reset again", {in_full, out_empty, err_wr, err_rd}, 4'b0100);

      done = 1'b1;
      report();
   end
endmodule